// File: doc/BRIEF.md
# Video Signature Capture Window

This block decides which pixels of a scanned frame feed a video signature, and it computes that signature. The raster timing generator supplies a horizontal pixel counter and a vertical line counter. Both count down. Software programs a first and a last count value for each axis. The block keeps one window flag per axis. The flag rises when its counter reaches the programmed first value and falls when the counter reaches the last value. The signature enable is high only while both flags are high.

While the enable is high, a 32-bit multiple-input signature register absorbs one 24-bit pixel per clock. A frame-sync pulse ends each frame. The pulse copies the running signature into a read-only result register, restarts the signature from a fixed seed value and closes the vertical window. A check can therefore compare the signature of one selected screen region from frame to frame. Three 32-bit registers are reachable through a simple write/read port.

Top module: `vsw_capture`

## Requirements
- R1: Register word 0 holds the horizontal bounds and word 1 holds the vertical bounds. In each word, bits 10:0 are the 11-bit first (open) value and bits 26:16 are the 11-bit last (close) value. A write takes effect on the next clock. Both words reset to zero, and the result word (word 2) also resets to zero. Only bits 26:16 and 10:0 of a bounds word are defined on read.
- R2: After a clock edge at which the horizontal counter equals the horizontal open value, the horizontal flag is set. This applies only when the counter does not also equal the close value.
- R3: After a clock edge at which the horizontal counter equals the horizontal close value, the horizontal flag is clear. The close match wins, so equal open and close values never open the window.
- R4: The vertical flag follows the same open, close and priority rules as R2 and R3, using the vertical counter and word 1.
- R5: A frame-sync pulse clears the vertical flag at that edge, so an open vertical window does not carry into the next frame.
- R6: `sig_en` is high exactly when both flags are high. The signature changes at no other time, apart from a frame sync.
- R7: At each edge where `sig_en` is high, the signature S becomes (S<<1) XOR (0x00400007 if S[31] was 1) XOR the zero-extended pixel. This is polynomial x^32+x^22+x^2+x+1.
- R8: At a frame-sync edge the result word takes the signature value from before that edge, and the signature reloads 0xFFFFFFFF. Frame sync takes priority over folding the pixel.
- R9: Word 2 is read-only. A write to it leaves the readable result unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| h_count | input | 11 | Horizontal pixel down counter |
| v_count | input | 11 | Vertical line down counter |
| frame_sync | input | 1 | One-cycle end-of-frame pulse |
| pix_data | input | 24 | Pixel sampled in this cycle |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register word select |
| wdata | input | 32 | Register write data |
| rdata | output | 32 | Register read data for `addr` (combinational) |
| sig_en | output | 1 | Signature enable (both flags high) |

## Verification
A window flag that opens or closes at the wrong count shows on `sig_en` one clock after the counter value that should have moved it, so a cycle-by-cycle comparison of `sig_en` over whole scanned frames finds it within the same line. A fault in the signature datapath or its seed stays hidden until the next frame sync. It then appears in word 2 on the very next read, because any single wrong fold changes every later signature value. A vertical flag that survives the frame sync shows as `sig_en` pulses in a frame whose vertical open value is never reached.

// File: rtl/vsw_pkg.sv
// Package: shared widths and signature constants for the video signature
// capture window. Assumes 32-bit register words with two 16-bit halves.
package vsw_pkg;
    localparam int CNT_W  = 11;
    localparam int PIX_W  = 24;
    localparam int SIG_W  = 32;
    localparam int REG_W  = 32;
    localparam int HALF_W = REG_W / 2;
    localparam logic [31:0] SIG_TAPS = 32'h0040_0007;
    localparam logic [31:0] SIG_SEED = 32'hFFFF_FFFF;

    typedef enum logic [1:0] {
        WORD_HBOUND = 2'd0,
        WORD_VBOUND = 2'd1,
        WORD_RESULT = 2'd2,
        WORD_NONE   = 2'd3
    } word_e;
endpackage

// File: rtl/vsw_bounds_regs.sv
// Bounds register file: holds the horizontal and vertical open/close values
// and multiplexes the read data. Assumes CNT_W <= HALF_W. The result word
// is supplied from outside and cannot be written here.
module vsw_bounds_regs
    import vsw_pkg::*;
#(
    parameter int CW = CNT_W,
    parameter int SW = SIG_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [1:0]    addr,
    input  logic [REG_W-1:0] wdata,
    input  logic [SW-1:0] result,
    output logic [REG_W-1:0] rdata,
    output logic [CW-1:0] h_open,
    output logic [CW-1:0] h_close,
    output logic [CW-1:0] v_open,
    output logic [CW-1:0] v_close
);
    localparam int PAD = HALF_W - CW;

    // Writes to the two bounds words; other words are not writable here.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h_open  <= '0;
            h_close <= '0;
            v_open  <= '0;
            v_close <= '0;
        end else if (wr_en) begin
            if (word_e'(addr) == WORD_HBOUND) begin
                h_open  <= wdata[CW-1:0];
                h_close <= wdata[HALF_W+CW-1:HALF_W];
            end else if (word_e'(addr) == WORD_VBOUND) begin
                v_open  <= wdata[CW-1:0];
                v_close <= wdata[HALF_W+CW-1:HALF_W];
            end
        end
    end

    // Read mux; the unused upper bits of each half read as zero.
    always_comb begin
        case (word_e'(addr))
            WORD_HBOUND: rdata = {{PAD{1'b0}}, h_close, {PAD{1'b0}}, h_open};
            WORD_VBOUND: rdata = {{PAD{1'b0}}, v_close, {PAD{1'b0}}, v_open};
            WORD_RESULT: rdata = REG_W'(result);
            default:     rdata = '0;
        endcase
    end
endmodule

// File: rtl/vsw_window.sv
// One-axis window flag: set when the down counter hits the open value,
// cleared when it hits the close value or when the clear input is high.
// Clearing takes priority over opening. Assumes one count per clock.
module vsw_window #(
    parameter int CW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] count,
    input  logic [CW-1:0] open_at,
    input  logic [CW-1:0] close_at,
    input  logic          clear,
    output logic          active
);
    logic hit_open;
    logic hit_close;

    // Compare the counter with both bounds.
    always_comb begin
        hit_open  = (count == open_at);
        hit_close = (count == close_at);
    end

    // Flag update with close/clear priority.
    always_ff @(posedge clk) begin
        if (!rst_n)
            active <= 1'b0;
        else if (clear || hit_close)
            active <= 1'b0;
        else if (hit_open)
            active <= 1'b1;
    end
endmodule

// File: rtl/vsw_misr.sv
// Multiple-input signature register: folds one pixel per enabled clock
// into a left-shifting LFSR with the given tap mask. It reloads the seed
// on reseed, which has priority over folding. Assumes PW <= SW.
module vsw_misr #(
    parameter int          SW   = 32,
    parameter int          PW   = 24,
    parameter logic [SW-1:0] TAPS = '0,
    parameter logic [SW-1:0] SEED = '1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          reseed,
    input  logic [PW-1:0] pix,
    output logic [SW-1:0] sig
);
    localparam int EXT = SW - PW;

    logic [SW-1:0] feedback;
    logic [SW-1:0] folded;

    // One signature step: shift, apply taps on carry-out, mix in the pixel.
    always_comb begin
        feedback = sig[SW-1] ? TAPS : '0;
        folded   = {sig[SW-2:0], 1'b0} ^ feedback ^ {{EXT{1'b0}}, pix};
    end

    // Signature state register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sig <= SEED;
        else if (reseed)
            sig <= SEED;
        else if (en)
            sig <= folded;
    end
endmodule

// File: rtl/vsw_capture.sv
// Top of the video signature capture window. Two window flags bounded by
// down-counter matches are ANDed into the signature enable. The signature
// is latched into a read-only result word and reseeded on each frame sync.
// Assumes the counters and pixel advance once per clk.
module vsw_capture
    import vsw_pkg::*;
#(
    parameter int CW = CNT_W,
    parameter int PW = PIX_W,
    parameter int SW = SIG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CW-1:0]    h_count,
    input  logic [CW-1:0]    v_count,
    input  logic             frame_sync,
    input  logic [PW-1:0]    pix_data,
    input  logic             wr_en,
    input  logic [1:0]       addr,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] rdata,
    output logic             sig_en
);
    logic [CW-1:0] h_open, h_close, v_open, v_close;
    logic          h_win, v_win;
    logic [SW-1:0] sig;
    logic [SW-1:0] result;

    vsw_bounds_regs #(.CW(CW), .SW(SW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .result(result), .rdata(rdata),
        .h_open(h_open), .h_close(h_close),
        .v_open(v_open), .v_close(v_close)
    );

    vsw_window #(.CW(CW)) u_hwin (
        .clk(clk), .rst_n(rst_n), .count(h_count),
        .open_at(h_open), .close_at(h_close),
        .clear(1'b0), .active(h_win)
    );

    vsw_window #(.CW(CW)) u_vwin (
        .clk(clk), .rst_n(rst_n), .count(v_count),
        .open_at(v_open), .close_at(v_close),
        .clear(frame_sync), .active(v_win)
    );

    // Enable is high only inside both axis windows.
    always_comb sig_en = h_win & v_win;

    vsw_misr #(.SW(SW), .PW(PW), .TAPS(SW'(SIG_TAPS)), .SEED(SW'(SIG_SEED))) u_misr (
        .clk(clk), .rst_n(rst_n), .en(sig_en), .reseed(frame_sync),
        .pix(pix_data), .sig(sig)
    );

    // Capture the finished signature at the end of each frame.
    always_ff @(posedge clk) begin
        if (!rst_n)
            result <= '0;
        else if (frame_sync)
            result <= sig;
    end
endmodule

// File: rtl/vsw_capture_chk.sv
// Checker for vsw_capture: window flag rules, signature hold, reseed and
// result capture. It is bound into every vsw_capture instance.
module vsw_capture_chk #(
    parameter int CW = 11,
    parameter int SW = 32,
    parameter logic [SW-1:0] SEED = '1
) (
    input logic          clk,
    input logic          rst_n,
    input logic [CW-1:0] h_count,
    input logic [CW-1:0] v_count,
    input logic [CW-1:0] h_open,
    input logic [CW-1:0] h_close,
    input logic [CW-1:0] v_open,
    input logic [CW-1:0] v_close,
    input logic          h_win,
    input logic          v_win,
    input logic          frame_sync,
    input logic          sig_en,
    input logic [SW-1:0] sig,
    input logic [SW-1:0] result
);
    p_hopen_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (h_count == h_open && h_count != h_close) |=> h_win);
    p_hclose_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (h_count == h_close) |=> !h_win);
    p_vopen_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (v_count == v_open && v_count != v_close && !frame_sync) |=> v_win);
    p_vclose_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (v_count == v_close) |=> !v_win);
    p_sync_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        frame_sync |=> !v_win);
    p_sig_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!sig_en && !frame_sync) |=> $stable(sig));
    p_reseed_r8: assert property (@(posedge clk) disable iff (!rst_n)
        frame_sync |=> (sig == SEED));
    p_capture_r8: assert property (@(posedge clk) disable iff (!rst_n)
        frame_sync |=> (result == $past(sig)));
    p_result_ro_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_sync |=> $stable(result));
endmodule

bind vsw_capture vsw_capture_chk #(
    .CW(CW), .SW(SW), .SEED(SW'(vsw_pkg::SIG_SEED))
) u_chk (
    .clk(clk), .rst_n(rst_n), .h_count(h_count), .v_count(v_count),
    .h_open(h_open), .h_close(h_close), .v_open(v_open), .v_close(v_close),
    .h_win(h_win), .v_win(v_win), .frame_sync(frame_sync),
    .sig_en(sig_en), .sig(sig), .result(result)
);

// File: tb/vsw_capture_tb.sv
`timescale 1ns/1ps
module vsw_capture_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [10:0] h_count, v_count;
    logic        frame_sync;
    logic [23:0] pix_data;
    logic        wr_en;
    logic [1:0]  addr;
    logic [31:0] wdata;
    logic [31:0] rdata;
    logic        sig_en;

    int n_chk = 0;
    int n_fail = 0;

    // Reference model state built from the requirements.
    bit          mh, mv;
    logic [31:0] msig, mres;
    logic [10:0] mho, mhc, mvo, mvc;

    localparam logic [31:0] SEED = 32'hFFFF_FFFF;
    localparam logic [31:0] TAPS = 32'h0040_0007;
    localparam logic [31:0] FIELD_MASK = 32'h07FF_07FF;

    always #2 clk = ~clk;

    vsw_capture u_dut (
        .clk(clk), .rst_n(rst_n), .h_count(h_count), .v_count(v_count),
        .frame_sync(frame_sync), .pix_data(pix_data), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .sig_en(sig_en)
    );

    function automatic logic [31:0] fold(logic [31:0] s, logic [23:0] p);
        return {s[30:0], 1'b0} ^ (s[31] ? TAPS : 32'h0) ^ {8'h00, p};
    endfunction

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One clock: the model takes the values on the ports at this edge.
    task automatic tick();
        bit en_old;
        @(posedge clk);
        en_old = mh & mv;
        if (rst_n) begin
            if (h_count == mhc) mh = 0; else if (h_count == mho) mh = 1;
            if (frame_sync || v_count == mvc) mv = 0; else if (v_count == mvo) mv = 1;
            if (frame_sync) begin mres = msig; msig = SEED; end
            else if (en_old) msig = fold(msig, pix_data);
            if (wr_en && addr == 2'd0) begin mho = wdata[10:0]; mhc = wdata[26:16]; end
            if (wr_en && addr == 2'd1) begin mvo = wdata[10:0]; mvc = wdata[26:16]; end
        end
        @(negedge clk);
    endtask

    task automatic wr(logic [1:0] a, logic [31:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, output logic [31:0] d);
        addr = a;
        #1 d = rdata;
    endtask

    // Scan one frame of W x L pixels, comparing sig_en each clock, then sync.
    task automatic scan_frame(int w, int l, int salt);
        logic [31:0] d;
        for (int ln = l - 1; ln >= 0; ln--) begin
            for (int px = w - 1; px >= 0; px--) begin
                h_count = 11'(px); v_count = 11'(ln);
                pix_data = 24'((px * 40503) ^ (ln * 7919) ^ salt);
                tick();
                check(sig_en == (mh & mv), "R2 R3 R4 R6 sig_en", {31'b0, sig_en}, {31'b0, mh & mv});
            end
        end
        frame_sync = 1'b1;
        tick();
        frame_sync = 1'b0;
        check(sig_en == 1'b0, "R5 sig_en after sync", {31'b0, sig_en}, 32'h0);
        rd(2'd2, d);
        check(d == mres, "R7 R8 result", d, mres);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(2'd0, d); check((d & FIELD_MASK) == 0, "R1 hbound reset", d & FIELD_MASK, 0);
        rd(2'd1, d); check((d & FIELD_MASK) == 0, "R1 vbound reset", d & FIELD_MASK, 0);
        rd(2'd2, d); check(d == 0, "R1 result reset", d, 0);
        check(sig_en == 1'b0, "R1 sig_en reset", {31'b0, sig_en}, 0);
    endtask

    task automatic t_regs();
        logic [31:0] d;
        wr(2'd0, 32'hFFFF_FFFF);
        rd(2'd0, d); check((d & FIELD_MASK) == FIELD_MASK, "R1 hbound all ones", d & FIELD_MASK, FIELD_MASK);
        wr(2'd1, 32'h0123_0456);
        rd(2'd1, d); check((d & FIELD_MASK) == 32'h0123_0456, "R1 vbound fields", d & FIELD_MASK, 32'h0123_0456);
    endtask

    task automatic frame_setup(int ho, int hc, int vo, int vc);
        wr(2'd0, {5'b0, 11'(hc), 5'b0, 11'(ho)});
        wr(2'd1, {5'b0, 11'(vc), 5'b0, 11'(vo)});
        frame_sync = 1'b1; tick(); frame_sync = 1'b0;
    endtask

    task automatic t_hwindow();
        frame_setup(30, 10, 11, 0);
        scan_frame(40, 12, 24'h00A5C3);
    endtask

    task automatic t_equal_bounds();
        frame_setup(20, 20, 11, 0);
        scan_frame(40, 12, 24'h123456);
        check(mres == SEED, "R3 equal bounds leave seed", mres, SEED);
    endtask

    task automatic t_vwindow();
        frame_setup(35, 2, 8, 3);
        scan_frame(40, 12, 24'h5A5A5A);
        frame_setup(39, 0, 11, 0);
        scan_frame(40, 12, 24'hFFFFFF);
    endtask

    task automatic t_sync_clear();
        frame_setup(30, 5, 9, 2047);
        scan_frame(40, 12, 24'h0F0F0F);
        frame_setup(30, 5, 1500, 1400);
        scan_frame(40, 12, 24'h777777);
        check(mres == SEED, "R5 no carried window", mres, SEED);
    endtask

    task automatic t_result_ro();
        logic [31:0] d;
        wr(2'd2, 32'h1234_5678);
        rd(2'd2, d); check(d == mres, "R9 result read-only", d, mres);
    endtask

    initial begin
        #(4 * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; h_count = '0; v_count = '0; frame_sync = 1'b0;
        pix_data = '0; wr_en = 1'b0; addr = '0; wdata = '0;
        mh = 0; mv = 0; msig = SEED; mres = '0;
        mho = '0; mhc = '0; mvo = '0; mvc = '0;
        @(negedge clk); tick(); tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_regs();
        t_hwindow();
        t_equal_bounds();
        t_vwindow();
        t_sync_clear();
        t_result_ro();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule